// File: doc/BRIEF.md
# Looping Tune Player

This block plays one built-in 64-step tune on a single-bit square-wave output. The output is meant to drive a small speaker through a series resistor. A free-running timebase counter sets the tempo. Its upper six bits select the current step. Each step maps to a 3-bit note code, and each note code maps to a 16-bit half-period count. A reloadable down-counter with a toggle flip-flop turns that count into the tone. Note code zero is a rest. When the last step ends, the tune starts again from step 0.

Two parameters scale the timing for simulation or for other clock rates. `STEP_LSB` sets the lowest timebase bit that forms the step index. At its default of 21, each step lasts 2^21 clocks. `DIV_SHIFT` shifts every half-period count right by that many bits. At its default of 0, the full 16-bit counts are used.

Top module: `melody_player`

## Requirements
- R1: While `rst` is high on a clock edge, `audio` is low after that edge and the timebase is cleared. Playback therefore always restarts at step 0.
- R2: The step index is timebase bits `[STEP_LSB+5:STEP_LSB]`, and the timebase advances by one on every clock outside reset. Each step therefore lasts exactly 2^STEP_LSB clocks.
- R3: The tune is defined as follows:
  - Steps 0–15 and steps 40–47 repeat the phrase 5,5,0,0,3,0,3,0.
  - Steps 32–39 are 6,6,0,0,7,0,6,0.
  - Steps 16–31 and steps 48–63 are both 5,0,4,0,3,0,2,0,1,1,1,1,0,0,0,0.
- R4: The half-period count D for each code is the value below, shifted right by `DIV_SHIFT`. Higher codes give higher pitch.

  | Code | Count |
  |------|-------|
  | 7 | 0x5E00 |
  | 6 | 0x6FC0 |
  | 5 | 0x7D70 |
  | 4 | 0x8CD0 |
  | 3 | 0x9530 |
  | 2 | 0xA770 |
  | 1 | 0xBBF0 |

- R5: Within a sounding note, the down-counter decrements to zero. At zero it reloads D and `audio` toggles, so each level lasts D+1 clocks and the duty cycle is 50%.
- R6: During a step whose code is 0, `audio` is held low and never toggles.
- R7: On the first clock edge where the note code differs from the previous clock's code, the counter loads the new D and `audio` keeps its level. The first toggle of the new note follows D+1 edges later.
- R8: After step 63 the tune wraps to step 0. Each pass produces the same output sequence as the pass that began at reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| audio | output | 1 | Square-wave speaker drive |

## Verification
The main stimulus is one uninterrupted pass through all 64 steps. It is followed by a short stretch of the second pass, which is compared bit by bit with the start of the first pass; this shows whether the wrap and the restart on a rest-to-note change match reset behaviour. Directed timing of the first high and low levels after reset separates a correct reload-on-change from one that waits for the counter to drain. Resets of random length at random points then show whether any state survives reset, for example a stale previous code that would suppress the reload.

// File: rtl/melody_pkg.sv
package melody_pkg;

  localparam int NOTE_W = 3;
  localparam int DIV_W  = 16;
  localparam int STEP_W = 6;

  typedef logic [NOTE_W-1:0] note_t;
  typedef logic [DIV_W-1:0]  div_t;
  typedef logic [STEP_W-1:0] step_t;

  // Strobes from the sequencing control to the tone datapath.
  typedef struct packed {
    logic silence;   // rest step: hold output low
    logic restart;   // note code changed: load new half period now
    div_t halfDiv;   // current half-period reload value
  } tone_cmd_t;

  // Tune lookup. Built from three phrases instead of one flat table:
  // the "head" phrase, the "bridge" phrase and the descending "tail".
  function automatic note_t tuneNote(input step_t step);
    note_t code;
    code = '0;
    if (step[4]) begin
      // second half of each 32-step half-tune: descending tail
      unique case (step[3:0])
        4'd0:    code = 3'd5;
        4'd2:    code = 3'd4;
        4'd4:    code = 3'd3;
        4'd6:    code = 3'd2;
        4'd8, 4'd9, 4'd10, 4'd11: code = 3'd1;
        default: code = 3'd0;
      endcase
    end else if (step[5] && !step[3]) begin
      // bridge phrase, steps 32..39
      unique case (step[2:0])
        3'd0, 3'd1, 3'd6: code = 3'd6;
        3'd4:             code = 3'd7;
        default:          code = 3'd0;
      endcase
    end else begin
      // head phrase, steps 0..15 and 40..47
      unique case (step[2:0])
        3'd0, 3'd1: code = 3'd5;
        3'd4, 3'd6: code = 3'd3;
        default:    code = 3'd0;
      endcase
    end
    return code;
  endfunction

  // Half-period reload for each pitch code; code 0 has none.
  function automatic div_t pitchDiv(input note_t code);
    div_t d;
    unique case (code)
      3'd1:    d = 16'hBBF0;
      3'd2:    d = 16'hA770;
      3'd3:    d = 16'h9530;
      3'd4:    d = 16'h8CD0;
      3'd5:    d = 16'h7D70;
      3'd6:    d = 16'h6FC0;
      3'd7:    d = 16'h5E00;
      default: d = 16'h0000;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/melody_control.sv
module melody_control
  import melody_pkg::*;
#(
  parameter int STEP_LSB  = 21,
  parameter int DIV_SHIFT = 0
) (
  input  logic      clk,
  input  logic      rst,
  output tone_cmd_t cmd,
  output note_t     noteCode,
  output note_t     prevCode,
  output logic [STEP_LSB+STEP_W-1:0] timebase
);

  localparam int TB_W = STEP_LSB + STEP_W;

  step_t stepIdx;
  div_t  rawDiv;

  // Free-running tempo counter; upper bits pick the step.
  always_ff @(posedge clk) begin
    if (rst) timebase <= '0;
    else     timebase <= timebase + 1'b1;
  end

  assign stepIdx  = timebase[TB_W-1:STEP_LSB];
  assign noteCode = tuneNote(stepIdx);
  assign rawDiv   = pitchDiv(noteCode);

  // Code seen on the previous clock, for change detection.
  always_ff @(posedge clk) begin
    if (rst) prevCode <= '0;
    else     prevCode <= noteCode;
  end

  always_comb begin
    cmd.silence = (noteCode == '0);
    cmd.restart = (noteCode != prevCode);
    cmd.halfDiv = rawDiv >> DIV_SHIFT;
  end

endmodule

// File: rtl/tone_datapath.sv
module tone_datapath
  import melody_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  tone_cmd_t cmd,
  output div_t      halfCnt,
  output logic      audio
);

  always_ff @(posedge clk) begin
    if (rst) begin
      halfCnt <= '0;
      audio   <= 1'b0;
    end else if (cmd.silence) begin
      halfCnt <= '0;
      audio   <= 1'b0;
    end else if (cmd.restart) begin
      halfCnt <= cmd.halfDiv;
    end else if (halfCnt == '0) begin
      halfCnt <= cmd.halfDiv;
      audio   <= ~audio;
    end else begin
      halfCnt <= halfCnt - 1'b1;
    end
  end

endmodule

// File: rtl/melody_player.sv
module melody_player
  import melody_pkg::*;
#(
  parameter int STEP_LSB  = 21,
  parameter int DIV_SHIFT = 0
) (
  input  logic clk,
  input  logic rst,
  output logic audio
);

  localparam int TB_W = STEP_LSB + STEP_W;

  tone_cmd_t        cmd;
  note_t            noteCode;
  note_t            prevCode;
  div_t             halfCnt;
  logic [TB_W-1:0]  timebase;

  melody_control #(
    .STEP_LSB (STEP_LSB),
    .DIV_SHIFT(DIV_SHIFT)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .noteCode(noteCode),
    .prevCode(prevCode),
    .timebase(timebase)
  );

  tone_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .halfCnt(halfCnt),
    .audio  (audio)
  );

endmodule

// File: rtl/melody_player_checker.sv
module melody_player_checker
  import melody_pkg::*;
#(
  parameter int STEP_LSB = 21
) (
  input logic clk,
  input logic rst,
  input logic audio,
  input note_t noteCode,
  input note_t prevCode,
  input div_t  halfCnt,
  input div_t  halfDiv,
  input logic [STEP_LSB+STEP_W-1:0] timebase
);

  // R1: reset clears the output and the tempo counter
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!audio && timebase == '0));

  // R2: tempo counter advances by one each clock
  p_timebase_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> timebase == $past(timebase) + 1'b1);

  // R6: a rest step leaves the output low
  p_rest_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (noteCode == '0) |=> !audio);

  // R7: a code change loads the new half period and keeps the level
  p_reload_on_change_r7: assert property (@(posedge clk) disable iff (rst)
    (noteCode != prevCode && noteCode != '0) |=>
      (halfCnt == $past(halfDiv) && audio == $past(audio)));

  // R5: toggle when a steady note's counter reaches zero
  p_toggle_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (halfCnt == '0 && noteCode != '0 && noteCode == prevCode) |=>
      audio != $past(audio));

  // R5: no toggle while the counter is still running
  p_hold_while_counting_r5: assert property (@(posedge clk) disable iff (rst)
    (halfCnt != '0 && noteCode != '0) |=> $stable(audio));

endmodule

bind melody_player melody_player_checker #(.STEP_LSB(STEP_LSB)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .audio   (audio),
  .noteCode(noteCode),
  .prevCode(prevCode),
  .halfCnt (halfCnt),
  .halfDiv (cmd.halfDiv),
  .timebase(timebase)
);

// File: tb/melody_player_test.sv
`timescale 1ns/1ps
module melody_player_test;

  localparam int STEP_LSB  = 10;
  localparam int DIV_SHIFT = 8;
  localparam int LOOP_LEN  = 64 << STEP_LSB;
  localparam int REC_LEN   = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic audio;

  always #2 clk = ~clk;

  melody_player #(.STEP_LSB(STEP_LSB), .DIV_SHIFT(DIV_SHIFT)) uut (
    .clk  (clk),
    .rst  (rst),
    .audio(audio)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  // reference state derived from the requirements
  int  mTime = 0;
  int  mPrev = 0;
  int  mCnt  = 0;
  bit  mAud  = 0;
  string mTag = "R1";
  bit  rec [REC_LEN];

  // R3: tune, written per step
  function automatic int refCode(int step);
    int head [8] = '{5,5,0,0,3,0,3,0};
    int brid [8] = '{6,6,0,0,7,0,6,0};
    int tail [16] = '{5,0,4,0,3,0,2,0,1,1,1,1,0,0,0,0};
    int s = step % 64;
    if (s < 16)      return head[s % 8];
    else if (s < 32) return tail[s - 16];
    else if (s < 40) return brid[s - 32];
    else if (s < 48) return head[s - 40];
    else             return tail[s - 48];
  endfunction

  // R4: half-period map
  function automatic int refHalf(int code);
    int v;
    case (code)
      1: v = 'hBBF0; 2: v = 'hA770; 3: v = 'h9530; 4: v = 'h8CD0;
      5: v = 'h7D70; 6: v = 'h6FC0; 7: v = 'h5E00; default: v = 0;
    endcase
    return v >> DIV_SHIFT;
  endfunction

  task automatic checkBit(bit got, bit exp, string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      if (fails < 20) $display("FAIL %s: audio=%0b expected %0b at t=%0d", tag, got, exp, mTime);
    end
  endtask

  task automatic checkInt(int got, int exp, string tag);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one clock: update reference at the edge, compare at the falling edge
  task automatic tick();
    int code;
    @(posedge clk);
    if (rst) begin
      mTime = 0; mPrev = 0; mCnt = 0; mAud = 0; mTag = "R1";
    end else begin
      code = refCode(mTime >> STEP_LSB);
      if (code == 0) begin
        mCnt = 0; mAud = 0; mTag = "R6";
      end else if (code != mPrev) begin
        mCnt = refHalf(code); mTag = "R7";
      end else if (mCnt == 0) begin
        mCnt = refHalf(code); mAud = ~mAud; mTag = "R4/R5";
      end else begin
        mCnt--; mTag = "R2/R3";
      end
      mPrev = code;
      mTime++;
    end
    @(negedge clk);
    checkBit(audio, mAud, mTag);
    if (!rst) begin
      if (mTime - 1 < REC_LEN) rec[mTime-1] = audio;
      else if (mTime - 1 >= LOOP_LEN && mTime - 1 < LOOP_LEN + REC_LEN)
        checkBit(audio, rec[mTime-1-LOOP_LEN], "R8 wrap repeat");
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (4) tick();
    checkBit(audio, 1'b0, "R1 during reset");
    rst = 1'b0;
    // R1/R7: first rise after release comes D+2 edges later (load, then D+1)
    n = 0;
    do begin tick(); n++; end while (audio == 1'b0 && n < 4000);
    checkInt(n, refHalf(5) + 2, "R1/R7 first rise");
    // R4/R5: high level lasts D+1 clocks
    n = 0;
    do begin tick(); n++; end while (audio == 1'b1 && n < 4000);
    checkInt(n, refHalf(5) + 1, "R4/R5 high width");
    // full pass plus start of second pass (R2, R3, R6, R8)
    while (mTime < LOOP_LEN + REC_LEN + 16) tick();
    // random resets at random points
    for (int k = 0; k < 5; k++) begin
      rst = 1'b1;
      repeat (1 + $urandom % 4) tick();
      checkBit(audio, 1'b0, "R1 reset mid-tune");
      rst = 1'b0;
      repeat (500 + $urandom % 3000) tick();
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule